// File: doc/BRIEF.md
# NAND Flash Access Timing Sequencer

This block runs a single bus cycle on an asynchronous NAND flash interface: a command byte, an address byte, a data read or a data write. Each cycle has several phases, and the length of each phase is programmed in bus clock cycles. The phases run in this order: setup, an optional read turnaround, strobe assertion, and hold. The strobe phase can be stretched by the flash's wait input. On writes, the data bus can be kept in high impedance for a programmed number of cycles at the start.

A host starts a cycle with a valid/ready handshake. The request carries the cycle kind, an 8-bit word and a 2-bit bank number. `req_ready` is high only while the sequencer is idle. A request held on `req_valid` while the block is busy simply waits, and nothing of it is latched until the handshake completes. When the cycle ends, `done` pulses for one clock. On reads, `rd_data` then holds the captured byte. The timing inputs are plain levels that the surrounding logic keeps loaded.

Top module: `nand_seq`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when `busy` is low. `busy` rises on the edge that accepts and falls on the edge that raises `done`. `done` is high for exactly one clock.
- R2: Setup phase:
  - The access begins with a setup phase of `cfg_setup`+1 cycles, with both strobes high.
  - CLE is high for the whole access when `req_kind`=0 (command).
  - ALE is high for the whole access when `req_kind`=1 (address).
  - Kinds 2 (read) and 3 (write) raise neither CLE nor ALE.
- R3: Strobe phase:
  - After setup, the strobe phase keeps WE low for kinds 0, 1 and 3, and RE low for kind 2.
  - It lasts `cfg_strobe`+1 cycles.
  - If `nand_wait_n` is low on the edge where the count has run out, the phase is extended until an edge finds it high.
- R4: After the strobe phase comes a hold phase of `cfg_hold`+1 cycles. In it both strobes are high, while CLE/ALE, CE and any driven data stay as they were.
- R5: Read turnaround:
  - A read that directly follows a command access inserts a turnaround of `cfg_cle_re`+1 cycles between setup and the RE strobe.
  - A read that directly follows an address access inserts `cfg_ale_re`+1 cycles instead.
  - Any other read has no turnaround.
- R6: Bus drive:
  - For kinds 0, 1 and 3, `nand_dq_oe` stays low for the first `cfg_hiz` cycles of the access and is high for the rest of it.
  - A value of 0 drives the bus from the first cycle.
  - For reads, `nand_dq_oe` is never high.
- R7: While busy, exactly the chip enable bit `nand_ce_n[req_bank]` latched at acceptance is low. While idle, all chip enable bits are high.
- R8: On a read, `rd_data` takes `nand_dq_in` on the edge where RE returns high, and holds it until the next read.
- R9: All timing inputs are sampled at acceptance. Changing them during an access does not change the length of any phase of that access.
- R10: While `nand_dq_oe` is high, `nand_dq_out` carries the word latched with the request.
- R11: Under reset and right after it:
  - `busy` and `done` are low, and `rd_data` is 0.
  - CLE and ALE are low.
  - RE, WE and all chip enables are high.
  - The first read has no turnaround.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 2 | 0 command, 1 address, 2 read, 3 write |
| req_word | input | 8 | Byte to drive for command, address or write |
| req_bank | input | 2 | Bank whose chip enable is used |
| cfg_cle_re | input | 4 | Command-to-read turnaround, n+1 cycles |
| cfg_ale_re | input | 4 | Address-to-read turnaround, n+1 cycles |
| cfg_hiz | input | 8 | Write high-impedance cycles, n cycles |
| cfg_hold | input | 8 | Hold phase, n+1 cycles |
| cfg_strobe | input | 8 | Strobe phase, n+1 cycles plus wait |
| cfg_setup | input | 8 | Setup phase, n+1 cycles |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock pulse at the end of an access |
| rd_data | output | 8 | Last captured read byte |
| nand_ce_n | output | 4 | Per-bank chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_wait_n | input | 1 | Low stretches the strobe phase |
| nand_dq_in | input | 8 | Data bus input |
| nand_dq_out | output | 8 | Data bus output |
| nand_dq_oe | output | 1 | Data bus output enable |

## Verification
The bench goes after four groups of corner cases:
- Off-by-one phase lengths. With every count at zero, a design that misses the n+1 rule would drop a phase or add one.
- Read turnaround choice. It covers reads right after a command, right after an address, and after another read. A design that keeps no memory of the previous kind would use the wrong turnaround or always insert one.
- High-impedance window. It covers a window of zero, a window inside the access, and one longer than the whole access. A wrong design would drive the bus early or hold it tristated in the wrong place.
- Stalls and mid-cycle changes. It covers a wait stall longer than the strobe count, a stall shorter than it, timing inputs changed mid-access, and `req_valid` held during an access. These expose a strobe that ignores or mis-samples the wait input, lengths that follow live inputs, and requests taken while busy.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_READ  = 2'd2,
    KIND_WRITE = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_TURN   = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4
  } phase_e;

endpackage

// File: rtl/nand_seq_cfg.sv
module nand_seq_cfg
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int DLY_W  = 4,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  kind_e             kind_in,
  input  logic [DATA_W-1:0] word_in,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [DLY_W-1:0]  cle_re_in,
  input  logic [DLY_W-1:0]  ale_re_in,
  input  logic [CNT_W-1:0]  hold_in,
  input  logic [CNT_W-1:0]  strobe_in,
  output kind_e             kind_q,
  output logic [DATA_W-1:0] word_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [CNT_W-1:0]  hold_q,
  output logic [CNT_W-1:0]  strobe_q,
  output logic              turn_en_q,
  output logic [DLY_W-1:0]  turn_len_q
);

  kind_e prev_kind_q;
  logic  prev_valid_q;
  logic  after_cmd, after_addr;

  assign after_cmd  = prev_valid_q && (prev_kind_q == KIND_CMD);
  assign after_addr = prev_valid_q && (prev_kind_q == KIND_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q       <= KIND_CMD;
      word_q       <= '0;
      bank_q       <= '0;
      hold_q       <= '0;
      strobe_q     <= '0;
      turn_en_q    <= 1'b0;
      turn_len_q   <= '0;
      prev_kind_q  <= KIND_CMD;
      prev_valid_q <= 1'b0;
    end else if (load) begin
      kind_q       <= kind_in;
      word_q       <= word_in;
      bank_q       <= bank_in;
      hold_q       <= hold_in;
      strobe_q     <= strobe_in;
      turn_en_q    <= (kind_in == KIND_READ) && (after_cmd || after_addr);
      turn_len_q   <= after_cmd ? cle_re_in : ale_re_in;
      prev_kind_q  <= kind_in;
      prev_valid_q <= 1'b1;
    end
  end

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] setup_in,
  input  logic             turn_en,
  input  logic [DLY_W-1:0] turn_len,
  input  logic [CNT_W-1:0] strobe_len,
  input  logic [CNT_W-1:0] hold_len,
  input  logic             wait_n,
  output phase_e           phase,
  output logic             strobe_end,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero   = (cnt_q == '0);
  assign strobe_end = (phase == PH_STROBE) && cnt_zero && wait_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (load) begin
            phase <= PH_SETUP;
            cnt_q <= setup_in;
          end
        end
        PH_SETUP: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (turn_en) begin
            phase <= PH_TURN;
            cnt_q <= CNT_W'(turn_len);
          end else begin
            phase <= PH_STROBE;
            cnt_q <= strobe_len;
          end
        end
        PH_TURN: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            phase <= PH_STROBE;
            cnt_q <= strobe_len;
          end
        end
        PH_STROBE: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (wait_n) begin
            phase <= PH_HOLD;
            cnt_q <= hold_len;
          end
        end
        PH_HOLD: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_seq_pins.sv
module nand_seq_pins
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int BANKS  = 4,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  kind_e             kind_in,
  input  logic [CNT_W-1:0]  hiz_in,
  input  phase_e            phase,
  input  logic              strobe_end,
  input  kind_e             kind_q,
  input  logic [DATA_W-1:0] word_q,
  input  logic [BANK_W-1:0] bank_q,
  input  logic [DATA_W-1:0] dq_in,
  output logic [BANKS-1:0]  ce_n,
  output logic              cle,
  output logic              ale,
  output logic              re_n,
  output logic              we_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_q
);

  logic             active;
  logic             is_read;
  logic [CNT_W-1:0] hiz_left_q;

  assign active  = (phase != PH_IDLE);
  assign is_read = (kind_q == KIND_READ);

  for (genvar b = 0; b < BANKS; b++) begin : g_ce
    assign ce_n[b] = !(active && (bank_q == BANK_W'(b)));
  end

  assign cle    = active && (kind_q == KIND_CMD);
  assign ale    = active && (kind_q == KIND_ADDR);
  assign we_n   = !((phase == PH_STROBE) && !is_read);
  assign re_n   = !((phase == PH_STROBE) && is_read);
  assign dq_oe  = active && !is_read && (hiz_left_q == '0);
  assign dq_out = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiz_left_q <= '0;
    end else if (load) begin
      hiz_left_q <= (kind_in == KIND_READ) ? '0 : hiz_in;
    end else if (active && (hiz_left_q != '0)) begin
      hiz_left_q <= hiz_left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (strobe_end && is_read) begin
      rd_q <= dq_in;
    end
  end

endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int DLY_W  = 4,
  parameter int BANKS  = 4,
  parameter int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_word,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [DLY_W-1:0]  cfg_cle_re,
  input  logic [DLY_W-1:0]  cfg_ale_re,
  input  logic [CNT_W-1:0]  cfg_hiz,
  input  logic [CNT_W-1:0]  cfg_hold,
  input  logic [CNT_W-1:0]  cfg_strobe,
  input  logic [CNT_W-1:0]  cfg_setup,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [BANKS-1:0]  nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_re_n,
  output logic              nand_we_n,
  input  logic              nand_wait_n,
  input  logic [DATA_W-1:0] nand_dq_in,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe
);

  phase_e            phase;
  logic              load;
  logic              strobe_end;
  kind_e             kind_in;
  kind_e             kind_q;
  logic [DATA_W-1:0] word_q;
  logic [BANK_W-1:0] bank_q;
  logic [CNT_W-1:0]  hold_q;
  logic [CNT_W-1:0]  strobe_q;
  logic              turn_en_q;
  logic [DLY_W-1:0]  turn_len_q;

  assign kind_in   = kind_e'(req_kind);
  assign busy      = (phase != PH_IDLE);
  assign req_ready = !busy;
  assign load      = req_valid && req_ready;

  nand_seq_cfg #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .DLY_W(DLY_W), .BANK_W(BANK_W)
  ) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .kind_in   (kind_in),
    .word_in   (req_word),
    .bank_in   (req_bank),
    .cle_re_in (cfg_cle_re),
    .ale_re_in (cfg_ale_re),
    .hold_in   (cfg_hold),
    .strobe_in (cfg_strobe),
    .kind_q    (kind_q),
    .word_q    (word_q),
    .bank_q    (bank_q),
    .hold_q    (hold_q),
    .strobe_q  (strobe_q),
    .turn_en_q (turn_en_q),
    .turn_len_q(turn_len_q)
  );

  nand_seq_fsm #(
    .CNT_W(CNT_W), .DLY_W(DLY_W)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .setup_in  (cfg_setup),
    .turn_en   (turn_en_q),
    .turn_len  (turn_len_q),
    .strobe_len(strobe_q),
    .hold_len  (hold_q),
    .wait_n    (nand_wait_n),
    .phase     (phase),
    .strobe_end(strobe_end),
    .done      (done)
  );

  nand_seq_pins #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .BANKS(BANKS), .BANK_W(BANK_W)
  ) pins_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .kind_in   (kind_in),
    .hiz_in    (cfg_hiz),
    .phase     (phase),
    .strobe_end(strobe_end),
    .kind_q    (kind_q),
    .word_q    (word_q),
    .bank_q    (bank_q),
    .dq_in     (nand_dq_in),
    .ce_n      (nand_ce_n),
    .cle       (nand_cle),
    .ale       (nand_ale),
    .re_n      (nand_re_n),
    .we_n      (nand_we_n),
    .dq_out    (nand_dq_out),
    .dq_oe     (nand_dq_oe),
    .rd_q      (rd_data)
  );

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
  parameter int DATA_W = 8,
  parameter int BANKS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rd_data,
  input logic [BANKS-1:0]  nand_ce_n,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic              nand_re_n,
  input logic              nand_we_n,
  input logic [DATA_W-1:0] nand_dq_in,
  input logic              nand_dq_oe
);

  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  ce_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(~nand_ce_n) == 1));

  // R7
  ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> $onehot0(~nand_ce_n) && (~nand_ce_n == '0));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_re_n && !nand_we_n));

  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R6
  read_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  // R4
  hold_cle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nand_we_n) && $past(nand_cle)) |-> nand_cle && busy);

  // R8
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nand_re_n) && busy) |-> (rd_data == $past(nand_dq_in)));

endmodule

bind nand_seq nand_seq_chk #(.DATA_W(DATA_W), .BANKS(BANKS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .rd_data   (rd_data),
  .nand_ce_n (nand_ce_n),
  .nand_cle  (nand_cle),
  .nand_ale  (nand_ale),
  .nand_re_n (nand_re_n),
  .nand_we_n (nand_we_n),
  .nand_dq_in(nand_dq_in),
  .nand_dq_oe(nand_dq_oe)
);

// File: tb/nand_seq_tb_top.sv
`timescale 1ns/1ps
module nand_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [7:0] req_word = 8'd0;
  logic [1:0] req_bank = 2'd0;
  logic [3:0] cfg_cle_re = 4'd0, cfg_ale_re = 4'd0;
  logic [7:0] cfg_hiz = 8'd0, cfg_hold = 8'd0, cfg_strobe = 8'd0, cfg_setup = 8'd0;
  logic       busy, done;
  logic [7:0] rd_data;
  logic [3:0] nand_ce_n;
  logic       nand_cle, nand_ale, nand_re_n, nand_we_n;
  logic       nand_wait_n = 1'b1;
  logic [7:0] nand_dq_in = 8'd0;
  logic [7:0] nand_dq_out;
  logic       nand_dq_oe;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] lcg = 8'h3c;

  always #5 clk = ~clk;

  nand_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_word(req_word), .req_bank(req_bank),
    .cfg_cle_re(cfg_cle_re), .cfg_ale_re(cfg_ale_re), .cfg_hiz(cfg_hiz),
    .cfg_hold(cfg_hold), .cfg_strobe(cfg_strobe), .cfg_setup(cfg_setup),
    .busy(busy), .done(done), .rd_data(rd_data), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_re_n(nand_re_n),
    .nand_we_n(nand_we_n), .nand_wait_n(nand_wait_n), .nand_dq_in(nand_dq_in),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe)
  );

  // Behavioural reference: phase 0 idle, 1 setup, 2 turnaround, 3 strobe, 4 hold
  int m_ph = 0, m_left = 0, m_hiz = 0, m_kind = 0, m_bank = 0, m_turn = 0;
  int m_hold = 0, m_strb = 0, m_prev = -1;
  logic [7:0] m_word = 0, m_rd = 0;
  bit m_done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_hiz = 0; m_rd = 0; m_done = 0; m_prev = -1;
      m_kind = 0; m_bank = 0; m_word = 0;
    end else begin
      m_done = 0;
      if (m_ph != 0 && m_hiz > 0) m_hiz = m_hiz - 1;
      case (m_ph)
        0: if (req_valid) begin
          m_kind = req_kind; m_word = req_word; m_bank = req_bank;
          m_hold = cfg_hold; m_strb = cfg_strobe;
          m_hiz  = (req_kind == 2) ? 0 : cfg_hiz;
          m_turn = (req_kind != 2) ? 0 : (m_prev == 0) ? cfg_cle_re + 1 :
                   (m_prev == 1) ? cfg_ale_re + 1 : 0;
          m_prev = req_kind;
          m_ph = 1; m_left = cfg_setup;
        end
        1: if (m_left > 0) m_left--;
           else if (m_turn > 0) begin m_ph = 2; m_left = m_turn - 1; end
           else begin m_ph = 3; m_left = m_strb; end
        2: if (m_left > 0) m_left--;
           else begin m_ph = 3; m_left = m_strb; end
        3: if (m_left > 0) m_left--;
           else if (nand_wait_n) begin
             if (m_kind == 2) m_rd = nand_dq_in;
             m_ph = 4; m_left = m_hold;
           end
        4: if (m_left > 0) m_left--;
           else begin m_ph = 0; m_done = 1; end
        default: m_ph = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      bit eb;
      logic [3:0] ece;
      eb = (m_ph != 0);
      ece = 4'hf;
      if (eb) ece[m_bank] = 1'b0;
      chk("R1 busy", busy, eb);
      chk("R1 ready", req_ready, !eb);
      chk("R1 done", done, m_done);
      chk("R7 ce_n", nand_ce_n, ece);
      chk("R2 cle", nand_cle, eb && m_kind == 0);
      chk("R2 ale", nand_ale, eb && m_kind == 1);
      chk("R3 we_n", nand_we_n, !(m_ph == 3 && m_kind != 2));
      chk("R3 re_n", nand_re_n, !(m_ph == 3 && m_kind == 2));
      chk("R6 dq_oe", nand_dq_oe, eb && m_kind != 2 && m_hiz == 0);
      if (nand_dq_oe) chk("R10 dq_out", nand_dq_out, m_word);
      chk("R8 rd_data", rd_data, m_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  int tb_prev = -1;

  task automatic run_access(input int k, input logic [7:0] w, input logic [1:0] b,
                            input int stall, input bit chg, input bit poke);
    int s, a, h, z, turn, nb, ns, npre, nh, ntri, guard, exp_str;
    bit seen;
    logic [7:0] last_re;
    s = cfg_setup; a = cfg_strobe; h = cfg_hold; z = cfg_hiz;
    turn = (k != 2) ? 0 : (tb_prev == 0) ? cfg_cle_re + 1 :
           (tb_prev == 1) ? cfg_ale_re + 1 : 0;
    tb_prev = k;
    nb = 0; ns = 0; npre = 0; nh = 0; ntri = 0; guard = 0; seen = 0; last_re = 0;
    @(negedge clk);
    req_valid = 1; req_kind = 2'(k); req_word = w; req_bank = b;
    do begin
      @(negedge clk);
      guard++;
      req_valid = poke && nb < 3;
      if (poke) req_kind = 2'd3;
      if (busy) begin
        nb++;
        if (!nand_dq_oe) ntri++;
        if (!nand_re_n || !nand_we_n) begin
          nand_wait_n = (ns >= stall);
          ns++; seen = 1;
        end else begin
          nand_wait_n = 1;
          if (seen) nh++; else npre++;
        end
      end
      lcg = lcg * 8'd29 + 8'd17;
      nand_dq_in = lcg;
      if (!nand_re_n) last_re = lcg;
      if (chg && nb == 2) begin
        cfg_setup = cfg_setup + 8'd4; cfg_strobe = cfg_strobe + 8'd3;
        cfg_hold = cfg_hold + 8'd5; cfg_hiz = cfg_hiz + 8'd2;
        cfg_cle_re = cfg_cle_re + 4'd1; cfg_ale_re = cfg_ale_re + 4'd1;
      end
    end while (!done && guard < 3000);
    req_valid = 0;
    nand_wait_n = 1;
    exp_str = ((a > stall) ? a : stall) + 1;
    chk("R1 done reached", done, 1);
    chk("R3 strobe cycles", ns, exp_str);
    chk(turn == 0 ? "R2 setup cycles" : "R5 setup+turnaround cycles", npre, s + 1 + turn);
    chk("R4 hold cycles", nh, h + 1);
    chk("R6 tristate cycles", ntri, (k == 2) ? nb : ((z < nb) ? z : nb));
    if (chg) chk("R9 total busy cycles", nb, s + 1 + turn + exp_str + h + 1);
    if (k == 2) chk("R8 captured byte", rd_data, last_re);
  endtask

  initial begin
    // R11 reset values
    #2;
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 ce_n", nand_ce_n, 4'hf);
    chk("R11 re_n/we_n", {nand_re_n, nand_we_n}, 2'b11);
    chk("R11 cle/ale", {nand_cle, nand_ale}, 2'b00);
    chk("R11 rd_data", rd_data, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 idle after reset", {busy, nand_ce_n}, 5'h0f);

    cfg_setup = 2; cfg_strobe = 3; cfg_hold = 1; cfg_hiz = 2;
    cfg_cle_re = 1; cfg_ale_re = 2;
    run_access(2, 8'h00, 2'd0, 0, 0, 0); // R11 first read: no turnaround
    run_access(0, 8'h70, 2'd1, 0, 0, 0);
    run_access(1, 8'h12, 2'd2, 0, 0, 0);
    run_access(2, 8'h00, 2'd2, 0, 0, 0); // R5 after address
    run_access(2, 8'h00, 2'd2, 0, 0, 0); // R5 after read: none
    run_access(0, 8'h90, 2'd3, 0, 0, 0);
    run_access(2, 8'h00, 2'd3, 0, 0, 0); // R5 after command
    cfg_hiz = 5;
    run_access(3, 8'ha5, 2'd3, 0, 0, 0);
    cfg_hiz = 0;
    run_access(3, 8'h5a, 2'd0, 0, 0, 0); // R6 zero window
    cfg_hiz = 200;
    run_access(3, 8'h3c, 2'd1, 0, 0, 0); // R6 window longer than access
    cfg_hiz = 1;
    run_access(2, 8'h00, 2'd1, 7, 0, 0); // R3 stall beyond count
    run_access(0, 8'hff, 2'd2, 2, 0, 0); // R3 stall inside count
    run_access(1, 8'h44, 2'd0, 0, 1, 0); // R9 mid-access change
    cfg_setup = 6; cfg_strobe = 4;
    run_access(3, 8'h81, 2'd2, 0, 0, 1); // R1 valid held while busy
    cfg_setup = 0; cfg_strobe = 0; cfg_hold = 0; cfg_hiz = 0;
    cfg_cle_re = 0; cfg_ale_re = 0;
    run_access(0, 8'h01, 2'd0, 0, 0, 0);
    run_access(2, 8'h00, 2'd0, 0, 0, 0); // R5 minimum turnaround
    cfg_cle_re = 15; cfg_hold = 9;
    run_access(0, 8'h02, 2'd3, 0, 0, 0);
    run_access(2, 8'h00, 2'd3, 3, 0, 0); // R5 maximum turnaround
    repeat (4) @(negedge clk);
    chk("R1 idle at end", busy, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule